// File: doc/BRIEF.md
# USB Host Endpoint-Zero Control Engine

This block is the host-side control/status register for the default control endpoint, together with the small sequencer behind it. Software writes an 8-bit register to say what it wants: a SETUP or OUT packet is loaded, an IN transfer is wanted, or the transfer is a status stage. The block turns that into a token request for an abstract packet engine. The packet engine reports one outcome per attempt: ACK, NAK, STALL, data received, or no response.

From those outcomes the engine keeps the data toggle and counts consecutive attempts that got no response. It halts the endpoint when NAKs persist past a frame-based limit. It updates the status bits software reads back and drives an interrupt line.

Top module: `usb_ep0_host_ctl`

Register bits, MSB first: bit 7 NAK-timeout halt, bit 6 status-stage, bit 5 IN request, bit 4 no-response error, bit 3 setup select, bit 2 stall seen, bit 1 transmit ready, bit 0 receive ready. Request kinds on `req_kind`: 0 = SETUP, 1 = OUT, 2 = IN. Outcome codes on `res_code`: 0 = ACK, 1 = NAK, 2 = STALL, 3 = data received, 4 = no response. Other codes are ignored.

## Requirements
- R1: After reset `csr` reads 0x00, `req_toggle` is 0, `req_valid` is 0 and `irq` is 0.
- R2: A write with bit 1 set raises `req_valid` with kind OUT (1). If bit 3 is set in the same write, the kind is SETUP (0) and the toggle becomes 0.
- R3: A write with bit 5 set requests kind IN (2). When bits 1 and 5 are both set, the OUT/SETUP request is served first and the IN request follows once it completes.
- R4: An ACK or data-received outcome on an OUT/SETUP request clears bits 1, 3 and 6 and inverts the toggle.
- R5: Bit 6 set in the same write as bit 1 or bit 5 forces the toggle to 1, and `req_status` follows bit 6.
- R6: A success outcome on an IN request sets bit 0, clears bits 5 and 6 and inverts the toggle. `svc_ack` clears bit 0. Software writes to bit 0 have no effect.
- R7: `irq` equals bit 4 OR (`irq_en` AND bit 0).
- R8: The third consecutive no-response outcome sets bit 4 and clears bits 1, 3, 5 and 6. Any other outcome restarts the count. Writing 0 to bit 4 clears it, and writing 1 leaves it unchanged.
- R9: With a non-zero `nak_limit`, bit 7 is set and `req_valid` drops on the `nak_limit`-th `frame_tick` after the first NAK of a request, unless a non-NAK outcome comes first. A limit of 0 never halts. Writing 0 to bit 7 resumes the request.
- R10: While `wr_lock` is high, register writes have no effect.
- R11: When a hardware event and a software write or `svc_ack` touch the same bit in the same cycle, the hardware value wins.
- R12: A STALL outcome sets bit 2 and clears bits 1, 3, 5 and 6. `req_valid` stays low while bit 2, bit 4 or bit 7 is set. Writing 0 to bit 2 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| wr_lock | input | 1 | Write protect; blocks register writes |
| svc_ack | input | 1 | Service acknowledge; clears receive ready |
| irq_en | input | 1 | Enables the receive-ready interrupt |
| nak_limit | input | LIM_W | NAK-timeout limit in frame ticks; 0 disables the timeout |
| frame_tick | input | 1 | One pulse per frame |
| req_valid | output | 1 | A transaction is requested |
| req_kind | output | 2 | 0 SETUP, 1 OUT, 2 IN |
| req_status | output | 1 | Request is a status-stage transaction |
| req_toggle | output | 1 | Data toggle for the request |
| res_valid | input | 1 | Outcome strobe from the packet engine |
| res_code | input | 3 | Outcome code |
| csr | output | 8 | Register read value |
| irq | output | 1 | Interrupt |

## Verification
The assertions assume that the packet engine reports an outcome only while `req_valid` is high, and at most one outcome per cycle. They also assume `nak_limit` is held steady while a NAK run is being timed. The stimulus gives each outcome only while a request is visibly pending. It changes `nak_limit` only while no NAK run is active. It raises `frame_tick` only in cycles without an outcome, so each timing window is counted exactly.

// File: rtl/usb_ep0_host_ctl.sv
module usb_ep0_host_ctl #(
  parameter int LIM_W    = 5,
  parameter int MISS_MAX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic             wr_lock,
  input  logic             svc_ack,
  input  logic             irq_en,
  input  logic [LIM_W-1:0] nak_limit,
  input  logic             frame_tick,
  output logic             req_valid,
  output logic [1:0]       req_kind,
  output logic             req_status,
  output logic             req_toggle,
  input  logic             res_valid,
  input  logic [2:0]       res_code,
  output logic [7:0]       csr,
  output logic             irq
);
  localparam int MISS_W = $clog2(MISS_MAX + 1);
  localparam logic [2:0] RC_ACK = 3'd0, RC_NAK = 3'd1, RC_STALL = 3'd2,
                         RC_DATA = 3'd3, RC_MISS = 3'd4;
  localparam logic [1:0] K_SETUP = 2'd0, K_OUT = 2'd1, K_IN = 2'd2;

  logic halt, stat, inreq, err, setup, stall, txr, rxr, tog;
  logic [MISS_W-1:0] miss_cnt;
  logic [LIM_W-1:0]  nak_cnt;
  logic              nak_run;

  assign csr        = {halt, stat, inreq, err, setup, stall, txr, rxr};
  assign req_valid  = (txr | inreq) & ~halt & ~err & ~stall;
  assign req_kind   = txr ? (setup ? K_SETUP : K_OUT) : K_IN;
  assign req_status = stat;
  assign req_toggle = tog;
  assign irq        = err | (irq_en & rxr);

  wire sw        = wr_en & ~wr_lock;
  wire take      = res_valid & req_valid;
  wire got_ok    = take & (res_code == RC_ACK || res_code == RC_DATA);
  wire got_nak   = take & (res_code == RC_NAK);
  wire got_stall = take & (res_code == RC_STALL);
  wire got_miss  = take & (res_code == RC_MISS);
  wire miss_last = got_miss && (miss_cnt == MISS_W'(MISS_MAX - 1));
  wire abort     = got_stall | miss_last;
  wire nak_step  = nak_run & frame_tick & ~take & (nak_limit != '0);
  wire nak_to    = nak_step & ({1'b0, nak_cnt} + 1'b1 >= {1'b0, nak_limit});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {halt, stat, inreq, err, setup, stall, txr, rxr, tog} <= '0;
      miss_cnt <= '0;
      nak_cnt  <= '0;
      nak_run  <= 1'b0;
    end else begin
      if (sw) begin
        stat  <= wr_data[6];
        inreq <= wr_data[5];
        setup <= wr_data[3];
        txr   <= wr_data[1];
        if (!wr_data[7]) halt  <= 1'b0;
        if (!wr_data[4]) err   <= 1'b0;
        if (!wr_data[2]) stall <= 1'b0;
        if (wr_data[3] & wr_data[1]) tog <= 1'b0;
        if (wr_data[6] & (wr_data[1] | wr_data[5])) tog <= 1'b1;
      end
      if (svc_ack) rxr <= 1'b0;

      if (got_ok) begin
        tog   <= ~tog;
        stat  <= 1'b0;
        setup <= 1'b0;
        if (txr) txr <= 1'b0;
        else begin
          inreq <= 1'b0;
          rxr   <= 1'b1;
        end
      end
      if (abort) begin
        txr   <= 1'b0;
        inreq <= 1'b0;
        stat  <= 1'b0;
        setup <= 1'b0;
      end
      if (got_stall) stall <= 1'b1;
      if (miss_last) err   <= 1'b1;

      if (got_miss)  miss_cnt <= miss_last ? '0 : miss_cnt + 1'b1;
      else if (take) miss_cnt <= '0;

      if (!req_valid || (take && !got_nak)) begin
        nak_run <= 1'b0;
        nak_cnt <= '0;
      end else if (got_nak) begin
        nak_run <= 1'b1;
      end else if (nak_to) begin
        halt    <= 1'b1;
        nak_run <= 1'b0;
        nak_cnt <= '0;
      end else if (nak_step) begin
        nak_cnt <= nak_cnt + 1'b1;
      end
    end
  end

  assert_setup_clears_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw && wr_data[3] && wr_data[1] && !wr_data[6] && !take) |=> (!req_toggle && req_kind == K_SETUP));

  assert_in_data_sets_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (got_ok && !txr) |=> (csr[0] && !csr[5]));

  assert_third_miss_error_R8: assert property (@(posedge clk) disable iff (!rst_n)
    miss_last |=> (csr[4] && !req_valid && irq));

  assert_halt_blocks_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    csr[7] |-> !req_valid);

  assert_lock_holds_csr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_lock && !res_valid && !svc_ack && !frame_tick) |=> $stable(csr));

  assert_stall_aborts_R12: assert property (@(posedge clk) disable iff (!rst_n)
    got_stall |=> (csr[2] && !csr[1] && !csr[5] && !req_valid));
endmodule

// File: tb/usb_ep0_host_ctl_bench.sv
`timescale 1ns/100ps
module usb_ep0_host_ctl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, wr_lock = 0, svc_ack = 0, irq_en = 1, frame_tick = 0, res_valid = 0;
  logic [7:0] wr_data = '0;
  logic [4:0] nak_limit = 5'd3;
  logic [2:0] res_code = '0;
  logic req_valid, req_status, req_toggle, irq;
  logic [1:0] req_kind;
  logic [7:0] csr;

  always #2.5 clk = ~clk;

  usb_ep0_host_ctl u_usb_ep0_host_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_lock(wr_lock),
    .svc_ack(svc_ack), .irq_en(irq_en), .nak_limit(nak_limit), .frame_tick(frame_tick),
    .req_valid(req_valid), .req_kind(req_kind), .req_status(req_status),
    .req_toggle(req_toggle), .res_valid(res_valid), .res_code(res_code),
    .csr(csr), .irq(irq));

  typedef struct { logic [13:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, failures = 0;
  bit done = 0;

  localparam logic [2:0] ACK = 0, NAK = 1, STALL = 2, DATA = 3, MISS = 4;

  function automatic logic [13:0] model(input logic [7:0] r, input logic t);
    logic v; logic [1:0] k;
    v = (r[1] | r[5]) & ~r[7] & ~r[4] & ~r[2];
    k = r[1] ? (r[3] ? 2'd0 : 2'd1) : 2'd2;
    return {r[4] | (irq_en & r[0]), v, k, r[6], t, r};
  endfunction

  task automatic expect_st(input logic [7:0] r, input logic t, input string tag);
    item_t it;
    it.exp = model(r, t);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cyc(input bit we, input logic [7:0] d, input bit lk, input bit sa,
                     input bit rv, input logic [2:0] rc, input bit ft);
    @(negedge clk);
    wr_en = we; wr_data = d; wr_lock = lk; svc_ack = sa;
    res_valid = rv; res_code = rc; frame_tick = ft;
    @(negedge clk);
    wr_en = 0; wr_lock = 0; svc_ack = 0; res_valid = 0; frame_tick = 0;
  endtask

  task automatic wr(input logic [7:0] d); cyc(1, d, 0, 0, 0, 0, 0); endtask
  task automatic res(input logic [2:0] c); cyc(0, 0, 0, 0, 1, c, 0); endtask
  task automatic tick(); cyc(0, 0, 0, 0, 0, 0, 1); endtask

  initial begin : monitor
    item_t it;
    logic [13:0] obs;
    forever begin
      wait (q.size() != 0);
      #1;
      it = q.pop_front();
      obs = {irq, req_valid, req_kind, req_status, req_toggle, csr};
      checks++;
      if (obs !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, obs, it.exp);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1;
    expect_st(8'h00, 0, "R1 reset");
    wr(8'h0A);            expect_st(8'h0A, 0, "R2 setup request, toggle 0");
    res(ACK);             expect_st(8'h00, 1, "R4 ack clears tx, flips toggle");
    wr(8'h20);            expect_st(8'h20, 1, "R3 IN request");
    res(DATA);            expect_st(8'h01, 0, "R6 data sets rx, R7 irq");
    @(negedge clk); irq_en = 0;
    expect_st(8'h01, 0, "R7 irq masked");
    @(negedge clk); irq_en = 1;
    wr(8'h01);            expect_st(8'h01, 0, "R6 write to rx bit ignored");
    cyc(1, 8'h02, 1, 0, 0, 0, 0); expect_st(8'h01, 0, "R10 locked write ignored");
    cyc(0, 0, 0, 1, 0, 0, 0);     expect_st(8'h00, 0, "R6 svc_ack clears rx");
    wr(8'h02);            expect_st(8'h02, 0, "R2 OUT request");
    res(MISS); res(MISS); expect_st(8'h02, 0, "R8 two misses no error");
    res(MISS);            expect_st(8'h10, 0, "R8 third miss sets error");
    wr(8'h10);            expect_st(8'h10, 0, "R8 writing 1 keeps error");
    wr(8'h00);            expect_st(8'h00, 0, "R8 writing 0 clears error");
    wr(8'h42);            expect_st(8'h42, 1, "R5 status forces toggle 1");
    res(STALL);           expect_st(8'h04, 1, "R12 stall aborts");
    wr(8'h00);            expect_st(8'h00, 1, "R12 stall cleared");
    wr(8'h02); res(NAK); tick(); tick();
    expect_st(8'h02, 1, "R9 two ticks no halt");
    tick();               expect_st(8'h82, 1, "R9 third tick halts");
    wr(8'h02);            expect_st(8'h02, 1, "R9 clearing halt resumes");
    nak_limit = 5'd0;
    res(NAK); repeat (5) tick();
    expect_st(8'h02, 1, "R9 zero limit never halts");
    res(ACK);             expect_st(8'h00, 0, "R4 ack after NAKs");
    nak_limit = 5'd3;
    wr(8'h02);
    cyc(1, 8'h00, 0, 0, 1, STALL, 0); expect_st(8'h04, 0, "R11 stall beats clearing write");
    wr(8'h00);
    wr(8'h20);
    cyc(0, 0, 0, 1, 1, DATA, 0);      expect_st(8'h01, 1, "R11 rx set beats svc_ack");
    cyc(0, 0, 0, 1, 0, 0, 0);
    wr(8'h02); res(MISS); res(MISS); res(NAK); res(MISS);
    expect_st(8'h02, 1, "R8 NAK restarts miss count");
    res(MISS); res(MISS); expect_st(8'h10, 1, "R8 error after fresh three misses");
    wr(8'h00);
    wr(8'h22);            expect_st(8'h22, 1, "R3 tx served before IN");
    res(ACK);             expect_st(8'h20, 0, "R3 IN follows");
    res(DATA);            expect_st(8'h01, 1, "R6 IN data after OUT");
    repeat (3) @(negedge clk);
    wait (q.size() == 0);
    #2;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule